// File: doc/BRIEF.md
# Tagged Dual-Source Memory Request Arbiter

The block lets two requesters share one request port of a memory controller. One requester is a software register bus, which may issue reads, writes and a mode-register load that changes the SDRAM operating parameters at run time. The other is a hardware unit that issues reads and writes only. Each command goes out with a tag that identifies its source. The controller returns that tag with every read data beat, and the block uses it to steer the beat to the right requester.

Commands pass straight through to the controller with no buffering. A write carries its first data word in the same cycle as the command. The block then holds the port for the rest of the burst and streams the remaining words from the owning source on consecutive cycles. When both sources are eligible in the same cycle, round-robin priority decides which one goes. A per-source credit counter limits how many reads each source can have outstanding.

Top module: `tagged_mem_arbiter`

## Requirements
- R1: Commands forwarded from the software source carry `mc_tag_o` = SW_TAG (default 0), and those from the hardware source carry HW_TAG (default 1).
- R2: A forwarded command presents the source's address on `mc_addr_o` and its command code on `mc_cmd_o`. Codes: 00 read, 01 write, 10 mode-register load. The hardware source sends 01 when `hw_we_i` is high and 00 otherwise.
- R3: A read return beat (`mc_rvalid_i`) pulses `sw_rvalid_o` when its tag equals SW_TAG and `hw_rvalid_o` when its tag equals HW_TAG, in the same cycle, with `mc_rdata_i` on the data outputs. A beat with any other tag raises neither output.
- R4: Software code 10 is forwarded as a mode-register load with the mode value on `mc_addr_o`. It raises no `mc_wbeat_o` and takes no read credit. The hardware source cannot issue it.
- R5: Software code 11 is ignored: it never causes `mc_valid_o`.
- R6: In the cycle a write command is accepted (`mc_valid_o` and `mc_ready_i`), `mc_wbeat_o` is high and `mc_wdata_o` carries the source's current `*_wdata_i`.
- R7: For the next BURST_LEN-1 cycles, `mc_wbeat_o` stays high and `mc_wdata_o` follows the owner's `*_wdata_i`. During these cycles `mc_valid_o` and both grants stay low.
- R8: When both sources are eligible, the one not granted most recently wins. After reset the software source wins first.
- R9: A single eligible source drives `mc_valid_o` in the same cycle. Its grant equals `mc_ready_i`.
- R10: A source with MAX_RD reads outstanding cannot start another read, but it can still write. A credit is returned by a beat with `mc_rlast_i` high and that source's tag.
- R11: While `mc_ready_i` is low, `mc_valid_o` may be high, but no grant is given and no state changes.
- R12: After reset `mc_valid_o`, `mc_wbeat_o`, both grants and both read-valid outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sw_req_i | input | 1 | Software request |
| sw_cmd_i | input | 2 | Software command code |
| sw_addr_i | input | AW | Software address or mode value |
| sw_wdata_i | input | DW | Software write data |
| sw_gnt_o | output | 1 | Software command accepted |
| sw_rvalid_o | output | 1 | Read beat for software |
| sw_rdata_o | output | DW | Read data for software |
| hw_req_i | input | 1 | Hardware unit request |
| hw_we_i | input | 1 | Hardware request is a write |
| hw_addr_i | input | AW | Hardware address |
| hw_wdata_i | input | DW | Hardware write data |
| hw_gnt_o | output | 1 | Hardware command accepted |
| hw_rvalid_o | output | 1 | Read beat for hardware unit |
| hw_rdata_o | output | DW | Read data for hardware unit |
| mc_valid_o | output | 1 | Command valid to controller |
| mc_ready_i | input | 1 | Controller accepts command |
| mc_cmd_o | output | 2 | Command code |
| mc_addr_o | output | AW | Command address |
| mc_tag_o | output | TAG_W | Source tag |
| mc_wbeat_o | output | 1 | Write data beat valid |
| mc_wdata_o | output | DW | Write data |
| mc_rvalid_i | input | 1 | Read beat valid |
| mc_rlast_i | input | 1 | Last beat of a read |
| mc_rtag_i | input | TAG_W | Tag returned with read beat |
| mc_rdata_i | input | DW | Read data |

## Verification
Some properties are checked on every cycle by assertions: at most one grant is given, round-robin alternation holds under contention, no command is issued while a burst owns the port, mode-register loads always carry the software tag, the two read-valid outputs are never high together, and the credit counters stay within bounds. Other behaviour needs the bench scenarios: exact command, address and tag values, the order of write beats, the effect of back-pressure, the refusal of reads at the credit limit while writes still pass, credit release only on the last beat, and a mode-register load leaving the credits untouched.

// File: rtl/tma_pkg.sv
package tma_pkg;
  typedef enum logic [1:0] {
    CMD_RD  = 2'b00,
    CMD_WR  = 2'b01,
    CMD_LMR = 2'b10,
    CMD_RSV = 2'b11
  } cmd_e;

  localparam int unsigned N_SRC  = 2;
  localparam int unsigned SRC_SW = 0;
  localparam int unsigned SRC_HW = 1;
endpackage

// File: rtl/tma_rr_pick.sv
module tma_rr_pick (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] elig_i,
  input  logic       adv_i,
  output logic [1:0] pick_o
);
  // 1: hardware granted last, so software wins the first tie
  logic last_hw_q;

  always_comb begin
    pick_o = 2'b00;
    if (elig_i == 2'b11) pick_o = last_hw_q ? 2'b01 : 2'b10;
    else                 pick_o = elig_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 last_hw_q <= 1'b1;
    else if (adv_i && |pick_o)   last_hw_q <= pick_o[1];
  end

  assert_one_pick_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(pick_o));

  assert_rr_alternate_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (elig_i == 2'b11 && adv_i) |=> (elig_i == 2'b11) |-> (pick_o != $past(pick_o)));
endmodule

// File: rtl/tma_rd_credit.sv
module tma_rd_credit #(
  parameter int unsigned MAX_RD = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic take_i,
  input  logic give_i,
  output logic ok_o
);
  localparam int unsigned CW = $clog2(MAX_RD + 1);

  logic [CW-1:0] cnt_q;

  assign ok_o = cnt_q < CW'(MAX_RD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (take_i && !give_i) cnt_q <= cnt_q + 1'b1;
    else if (give_i && !take_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assert_no_overflow_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && !give_i) |-> (cnt_q < CW'(MAX_RD)));

  assert_within_limit_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(MAX_RD));
endmodule

// File: rtl/tma_burst_lock.sv
module tma_burst_lock #(
  parameter int unsigned BURST_LEN = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic owner_i,
  output logic busy_o,
  output logic owner_o
);
  generate
    if (BURST_LEN > 1) begin : g_lock
      localparam int unsigned BW = $clog2(BURST_LEN);
      logic [BW-1:0] left_q;
      logic          own_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          left_q <= '0;
          own_q  <= 1'b0;
        end else if (start_i) begin
          left_q <= BW'(BURST_LEN - 1);
          own_q  <= owner_i;
        end else if (left_q != '0) begin
          left_q <= left_q - 1'b1;
        end
      end

      assign busy_o  = left_q != '0;
      assign owner_o = own_q;

      assert_lock_no_restart_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_o |-> !start_i);

      assert_lock_owner_stable_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && $past(busy_o)) |-> $stable(owner_o));
    end else begin : g_nolock
      assign busy_o  = 1'b0;
      assign owner_o = owner_i;
    end
  endgenerate
endmodule

// File: rtl/tagged_mem_arbiter.sv
module tagged_mem_arbiter
  import tma_pkg::*;
#(
  parameter int unsigned AW        = 16,
  parameter int unsigned DW        = 32,
  parameter int unsigned TAG_W     = 2,
  parameter int unsigned BURST_LEN = 4,
  parameter int unsigned MAX_RD    = 2,
  parameter int unsigned SW_TAG    = 0,
  parameter int unsigned HW_TAG    = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sw_req_i,
  input  logic [1:0]       sw_cmd_i,
  input  logic [AW-1:0]    sw_addr_i,
  input  logic [DW-1:0]    sw_wdata_i,
  output logic             sw_gnt_o,
  output logic             sw_rvalid_o,
  output logic [DW-1:0]    sw_rdata_o,
  input  logic             hw_req_i,
  input  logic             hw_we_i,
  input  logic [AW-1:0]    hw_addr_i,
  input  logic [DW-1:0]    hw_wdata_i,
  output logic             hw_gnt_o,
  output logic             hw_rvalid_o,
  output logic [DW-1:0]    hw_rdata_o,
  output logic             mc_valid_o,
  input  logic             mc_ready_i,
  output logic [1:0]       mc_cmd_o,
  output logic [AW-1:0]    mc_addr_o,
  output logic [TAG_W-1:0] mc_tag_o,
  output logic             mc_wbeat_o,
  output logic [DW-1:0]    mc_wdata_o,
  input  logic             mc_rvalid_i,
  input  logic             mc_rlast_i,
  input  logic [TAG_W-1:0] mc_rtag_i,
  input  logic [DW-1:0]    mc_rdata_i
);
  localparam logic [TAG_W-1:0] TAG_SW = TAG_W'(SW_TAG);
  localparam logic [TAG_W-1:0] TAG_HW = TAG_W'(HW_TAG);

  logic [N_SRC-1:0][TAG_W-1:0] tag_of;
  logic [N_SRC-1:0][1:0]       cmd_of;
  logic [N_SRC-1:0][AW-1:0]    addr_of;
  logic [N_SRC-1:0][DW-1:0]    wdata_of;
  logic [N_SRC-1:0]            req_of, cmd_ok, rd_ok, elig, pick, take, give, rtag_hit;
  logic                        busy, owner, sel, accept, start;

  assign tag_of   = {TAG_HW, TAG_SW};
  assign cmd_of   = {(hw_we_i ? CMD_WR : CMD_RD), sw_cmd_i};
  assign addr_of  = {hw_addr_i, sw_addr_i};
  assign wdata_of = {hw_wdata_i, sw_wdata_i};
  assign req_of   = {hw_req_i, sw_req_i};
  assign cmd_ok   = {1'b1, (sw_cmd_i != CMD_RSV)};

  generate
    for (genvar s = 0; s < N_SRC; s++) begin : g_src
      assign elig[s]     = req_of[s] && cmd_ok[s] && !busy && (cmd_of[s] != CMD_RD || rd_ok[s]);
      assign take[s]     = accept && pick[s] && cmd_of[s] == CMD_RD;
      assign rtag_hit[s] = mc_rvalid_i && mc_rtag_i == tag_of[s];
      assign give[s]     = rtag_hit[s] && mc_rlast_i;

      tma_rd_credit #(.MAX_RD(MAX_RD)) i_credit (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .take_i (take[s]),
        .give_i (give[s]),
        .ok_o   (rd_ok[s])
      );
    end
  endgenerate

  tma_rr_pick i_pick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .elig_i (elig),
    .adv_i  (accept),
    .pick_o (pick)
  );

  assign sel        = pick[SRC_HW];
  assign mc_valid_o = |pick;
  assign accept     = mc_valid_o && mc_ready_i;
  assign start      = accept && cmd_of[sel] == CMD_WR;

  tma_burst_lock #(.BURST_LEN(BURST_LEN)) i_lock (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .owner_i (sel),
    .busy_o  (busy),
    .owner_o (owner)
  );

  assign mc_cmd_o   = mc_valid_o ? cmd_of[sel] : CMD_RD;
  assign mc_addr_o  = addr_of[sel];
  assign mc_tag_o   = busy ? tag_of[owner] : tag_of[sel];
  assign mc_wbeat_o = busy || start;
  assign mc_wdata_o = busy ? wdata_of[owner] : wdata_of[sel];

  assign sw_gnt_o = pick[SRC_SW] && mc_ready_i;
  assign hw_gnt_o = pick[SRC_HW] && mc_ready_i;

  assign sw_rvalid_o = rtag_hit[SRC_SW];
  assign hw_rvalid_o = rtag_hit[SRC_HW];
  assign sw_rdata_o  = mc_rdata_i;
  assign hw_rdata_o  = mc_rdata_i;

  assert_lock_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> (!mc_valid_o && !sw_gnt_o && !hw_gnt_o && mc_wbeat_o));

  assert_write_beat_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && mc_cmd_o == CMD_WR) |-> mc_wbeat_o);

  assert_lmr_sw_only_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mc_valid_o && mc_cmd_o == CMD_LMR) |-> (mc_tag_o == TAG_SW && !mc_wbeat_o));

  assert_rsv_blocked_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mc_valid_o |-> mc_cmd_o != CMD_RSV);

  assert_route_excl_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sw_rvalid_o && hw_rvalid_o));

  assert_no_grant_stall_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mc_ready_i |-> (!sw_gnt_o && !hw_gnt_o));
endmodule

// File: tb/test_tagged_mem_arbiter.sv
module test_tagged_mem_arbiter;
  localparam int AW = 16, DW = 32, TW = 2;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  always #2 clk_i = ~clk_i;

  logic          sw_req_i = 0, hw_req_i = 0, hw_we_i = 0, mc_ready_i = 1;
  logic [1:0]    sw_cmd_i = 0;
  logic [AW-1:0] sw_addr_i = 0, hw_addr_i = 0;
  logic [DW-1:0] sw_wdata_i = 0, hw_wdata_i = 0, mc_rdata_i = 0;
  logic          mc_rvalid_i = 0, mc_rlast_i = 0;
  logic [TW-1:0] mc_rtag_i = 0;
  logic          sw_gnt_o, hw_gnt_o, sw_rvalid_o, hw_rvalid_o, mc_valid_o, mc_wbeat_o;
  logic [DW-1:0] sw_rdata_o, hw_rdata_o, mc_wdata_o;
  logic [1:0]    mc_cmd_o;
  logic [AW-1:0] mc_addr_o;
  logic [TW-1:0] mc_tag_o;

  tagged_mem_arbiter i_tagged_mem_arbiter (.*);

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [19:0] exp_cmd_q[$];
  logic [31:0] exp_beat_q[$], exp_sw_q[$], exp_hw_q[$];

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic tick();  @(posedge clk_i); #1; endtask
  task automatic at_neg(); @(negedge clk_i); endtask

  task automatic idle();
    sw_req_i = 0; hw_req_i = 0; hw_we_i = 0; sw_cmd_i = 0; mc_rvalid_i = 0; mc_rlast_i = 0;
  endtask

  task automatic exp_cmd(logic [1:0] c, logic [15:0] a, logic [1:0] t);
    exp_cmd_q.push_back({c, a, t});
  endtask

  task automatic ret(logic [1:0] t, logic last, logic [31:0] d);
    mc_rvalid_i = 1; mc_rtag_i = t; mc_rlast_i = last; mc_rdata_i = d;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // scoreboard monitor
  always @(negedge clk_i) if (rst_ni && !done) begin
    if (mc_valid_o && mc_ready_i) begin
      if (exp_cmd_q.size() == 0) chk("R2 unexpected command", 32'(mc_addr_o), 32'hdead);
      else chk("R1/R2 command cmd,addr,tag", 32'({mc_cmd_o, mc_addr_o, mc_tag_o}), 32'(exp_cmd_q.pop_front()));
    end
    if (mc_wbeat_o) begin
      if (exp_beat_q.size() == 0) chk("R6/R7 unexpected beat", mc_wdata_o, 32'hdead);
      else chk("R6/R7 write beat", mc_wdata_o, exp_beat_q.pop_front());
    end
    if (sw_rvalid_o) begin
      if (exp_sw_q.size() == 0) chk("R3 unexpected sw read", sw_rdata_o, 32'hdead);
      else chk("R3 sw read data", sw_rdata_o, exp_sw_q.pop_front());
    end
    if (hw_rvalid_o) begin
      if (exp_hw_q.size() == 0) chk("R3 unexpected hw read", hw_rdata_o, 32'hdead);
      else chk("R3 hw read data", hw_rdata_o, exp_hw_q.pop_front());
    end
  end

  initial begin
    #400000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // R12 reset state
    #3;
    chk("R12 mc_valid_o", 32'(mc_valid_o), 0);
    chk("R12 mc_wbeat_o", 32'(mc_wbeat_o), 0);
    chk("R12 grants", 32'({sw_gnt_o, hw_gnt_o}), 0);
    chk("R12 rvalids", 32'({sw_rvalid_o, hw_rvalid_o}), 0);
    at_neg(); rst_ni = 1;

    // R8 tie after reset: software first, then hardware (R1 tags)
    tick(); sw_req_i = 1; sw_cmd_i = 2'b00; sw_addr_i = 16'h0010;
    hw_req_i = 1; hw_we_i = 0; hw_addr_i = 16'h0020;
    exp_cmd(2'b00, 16'h0010, 2'd0);
    at_neg(); chk("R8 first tie sw wins", 32'({sw_gnt_o, hw_gnt_o}), 32'b10);
    tick(); sw_req_i = 0; exp_cmd(2'b00, 16'h0020, 2'd1);
    at_neg(); chk("R9 lone hw granted", 32'(hw_gnt_o), 1);
    tick(); idle();

    // R3 routing by tag
    ret(2'd1, 1, 32'hAAAA0001); exp_hw_q.push_back(32'hAAAA0001);
    tick(); ret(2'd0, 1, 32'hBBBB0002); exp_sw_q.push_back(32'hBBBB0002);
    tick(); ret(2'd3, 1, 32'hCCCC0003);
    at_neg(); chk("R3 foreign tag dropped", 32'({sw_rvalid_o, hw_rvalid_o}), 0);
    tick(); idle();

    // R6/R7 hw write burst, sw request held off during the burst
    hw_req_i = 1; hw_we_i = 1; hw_addr_i = 16'h0030; hw_wdata_i = 32'h11110000;
    exp_cmd(2'b01, 16'h0030, 2'd1);
    for (int i = 0; i < 4; i++) exp_beat_q.push_back(32'h11110000 + i);
    at_neg(); chk("R6 beat with command", 32'(mc_wbeat_o), 1);
    for (int i = 1; i < 4; i++) begin
      tick(); hw_req_i = 0; hw_wdata_i = 32'h11110000 + i;
      sw_req_i = 1; sw_cmd_i = 2'b00; sw_addr_i = 16'h0040;
      at_neg();
      chk("R7 no command during burst", 32'(mc_valid_o), 0);
      chk("R7 no grant during burst", 32'({sw_gnt_o, hw_gnt_o}), 0);
      chk("R1 burst tag", 32'(mc_tag_o), 1);
    end
    tick(); exp_cmd(2'b00, 16'h0040, 2'd0);
    at_neg(); chk("R7 grant after burst", 32'(sw_gnt_o), 1);
    tick(); idle();

    // R8 round robin: last was sw, so hw wins the tie
    sw_req_i = 1; sw_cmd_i = 2'b00; sw_addr_i = 16'h0050;
    hw_req_i = 1; hw_we_i = 0; hw_addr_i = 16'h0060;
    exp_cmd(2'b00, 16'h0060, 2'd1);
    at_neg(); chk("R8 tie alternates to hw", 32'({sw_gnt_o, hw_gnt_o}), 32'b01);
    tick(); hw_req_i = 0; exp_cmd(2'b00, 16'h0050, 2'd0);
    at_neg(); chk("R8 sw next", 32'(sw_gnt_o), 1);

    // R10 sw now has 2 reads outstanding
    tick(); sw_addr_i = 16'h0058;
    at_neg(); chk("R10 read blocked at limit", 32'(mc_valid_o), 0);
    tick();
    at_neg(); chk("R10 read still blocked", 32'(mc_valid_o), 0);
    tick(); sw_cmd_i = 2'b01; sw_addr_i = 16'h0070; sw_wdata_i = 32'h22220000;
    exp_cmd(2'b01, 16'h0070, 2'd0);
    for (int i = 0; i < 4; i++) exp_beat_q.push_back(32'h22220000 + i);
    at_neg(); chk("R10 write allowed at limit", 32'(sw_gnt_o), 1);
    for (int i = 1; i < 4; i++) begin
      tick(); sw_req_i = 0; sw_wdata_i = 32'h22220000 + i;
    end
    tick(); ret(2'd0, 0, 32'hD0D00001); exp_sw_q.push_back(32'hD0D00001);
    sw_req_i = 1; sw_cmd_i = 2'b00; sw_addr_i = 16'h0080;
    at_neg(); chk("R10 non-last beat keeps limit", 32'(mc_valid_o), 0);
    tick(); ret(2'd0, 1, 32'hD0D00002); exp_sw_q.push_back(32'hD0D00002);
    at_neg(); chk("R10 still blocked on release cycle", 32'(mc_valid_o), 0);
    tick(); mc_rvalid_i = 0; exp_cmd(2'b00, 16'h0080, 2'd0);
    at_neg(); chk("R10 read after credit return", 32'(sw_gnt_o), 1);
    tick(); idle();
    ret(2'd0, 1, 32'hE0E00001); exp_sw_q.push_back(32'hE0E00001);
    tick(); ret(2'd0, 1, 32'hE0E00002); exp_sw_q.push_back(32'hE0E00002);
    tick(); ret(2'd1, 1, 32'hE0E00003); exp_hw_q.push_back(32'hE0E00003);
    tick(); idle();

    // R11 back-pressure
    mc_ready_i = 0; sw_req_i = 1; sw_cmd_i = 2'b00; sw_addr_i = 16'h0090;
    at_neg();
    chk("R11 valid under stall", 32'(mc_valid_o), 1);
    chk("R11 no grant under stall", 32'(sw_gnt_o), 0);
    tick(); mc_ready_i = 1; exp_cmd(2'b00, 16'h0090, 2'd0);
    at_neg(); chk("R11 grant after stall", 32'(sw_gnt_o), 1);

    // R4 mode-register load
    tick(); sw_cmd_i = 2'b10; sw_addr_i = 16'h0123; exp_cmd(2'b10, 16'h0123, 2'd0);
    at_neg(); chk("R4 no write beat", 32'(mc_wbeat_o), 0);
    tick(); sw_cmd_i = 2'b00; sw_addr_i = 16'h00A0; exp_cmd(2'b00, 16'h00A0, 2'd0);
    at_neg(); chk("R4 load took no credit", 32'(sw_gnt_o), 1);
    tick(); sw_addr_i = 16'h00B0;
    at_neg(); chk("R10 limit reached again", 32'(mc_valid_o), 0);

    // R5 reserved code
    tick(); sw_cmd_i = 2'b11; sw_addr_i = 16'h00C0;
    at_neg(); chk("R5 reserved ignored", 32'({mc_valid_o, mc_wbeat_o}), 0);
    tick(); idle();
    tick(); at_neg();
    done = 1;
    chk("R2 all commands seen", 32'(exp_cmd_q.size()), 0);
    chk("R7 all beats seen", 32'(exp_beat_q.size()), 0);
    chk("R3 all returns seen", 32'(exp_sw_q.size() + exp_hw_q.size()), 0);
    finish_run();
  end
endmodule